// File: doc/BRIEF.md
# Auto-Reloading Down-Count Timer

This block is a down-counter that steps once per time base tick and reports an expiry when the count passes from one to zero. A status and control block elsewhere in the chip uses the one-cycle expiry pulse to set its decrementer status bit. Interrupt masking belongs to that block, not to this one.

Software can load the counter directly through a write port. It can also program a separate reload register. When the count expires, the counter takes the reload value, but only if reload is enabled and the reload value is nonzero. A reload value of zero therefore leaves the counter parked at zero and cannot cause an endless stream of expiries. Without reload, the counter stays at zero and stays silent until software loads it again.

Top module: `dec_reload_timer`

## Requirements
- R1: After reset, `count_o` and `reload_o` are zero and `expire_o` is low.
- R2: When `tick_en` is high, `cnt_wr_en` is low and the count is above one, the count drops by exactly one at the next clock edge. Without a tick and without a write, the count holds.
- R3: `expire_o` is high for exactly one cycle. That cycle is the one after the edge where a tick, with no write, met a count of one.
- R4: On an expiry with `rld_enable` high and a nonzero reload register, the count becomes the reload register value at the same edge.
- R5: On an expiry with `rld_enable` low, the count becomes zero. It then stays zero with no further expiry while ticks continue, until software writes the counter.
- R6: On an expiry with `rld_enable` high and a reload register of zero, the count becomes zero and no further expiry follows.
- R7: A counter write (`cnt_wr_en` high) loads `cnt_wr_data` at the next edge. It takes priority over a decrement or reload in the same cycle, and that cycle produces no expiry even if the count was one.
- R8: Writing zero to the counter, or ticking while the count is zero, produces no expiry.
- R9: A reload register write (`rld_wr_en` high) shows on `reload_o` after the next edge. An expiry in the same cycle as such a write reloads the value the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time base tick, one decrement per high cycle |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | CNT_W | Counter write value |
| rld_wr_en | input | 1 | Reload register write strobe |
| rld_wr_data | input | CNT_W | Reload register write value |
| rld_enable | input | 1 | Reload on expiry enabled (from control register) |
| count_o | output | CNT_W | Present count |
| reload_o | output | CNT_W | Present reload register value |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume that every input is a known value at each clock edge after reset. They also assume that `tick_en` may arrive in any cycle, including back to back, so no spacing between ticks is taken for granted. The stimulus always drives defined values on the falling edge. It keeps counter and reload values small, so that expiries, reloads of one, zero reloads and writes landing on a count of one all occur many times. A few directed sequences pin down the write-versus-expiry and reload-write-versus-expiry collisions.

// File: rtl/dec_pkg.sv
package dec_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_STEP   = 2'd2,
      ACT_EXPIRE = 2'd3
   } dec_act_e;
endpackage

// File: rtl/dec_action_sel.sv
module dec_action_sel
   import dec_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             tick_en,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] count,
   output dec_act_e         act
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      if (cnt_wr_en)
         act = ACT_LOAD;
      else if (tick_en && count == ONE)
         act = ACT_EXPIRE;
      else if (tick_en && count != '0)
         act = ACT_STEP;
      else
         act = ACT_HOLD;
   end
endmodule

// File: rtl/dec_reload_reg.sv
module dec_reload_reg #(
   parameter int CNT_W     = 32,
   parameter bit RELOAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] value
);
   generate
      if (RELOAD_EN) begin : g_store
         logic [CNT_W-1:0] held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= '0;
            else if (wr_en)
               held_q <= wr_data;
         end
         assign value = held_q;
      end else begin : g_none
         logic unused_w;
         assign unused_w = wr_en ^ (^wr_data) ^ clk ^ rst_n;
         assign value    = '0;
      end
   endgenerate
endmodule

// File: rtl/dec_count_reg.sv
module dec_count_reg
   import dec_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dec_act_e         act,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rld_enable,
   input  logic [CNT_W-1:0] rld_value,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             exp_q;
   logic             do_reload;

   assign do_reload = rld_enable && (rld_value != '0);

   always_comb begin
      unique case (act)
         ACT_LOAD:   cnt_d = wr_data;
         ACT_STEP:   cnt_d = cnt_q - ONE;
         ACT_EXPIRE: cnt_d = do_reload ? rld_value : '0;
         default:    cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         exp_q <= (act == ACT_EXPIRE);
      end
   end

   assign count  = cnt_q;
   assign expire = exp_q;
endmodule

// File: rtl/dec_reload_timer.sv
module dec_reload_timer
   import dec_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter bit RELOAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic             rld_wr_en,
   input  logic [CNT_W-1:0] rld_wr_data,
   input  logic             rld_enable,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             expire_o
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("dec_reload_timer: CNT_W must lie in 2..64");
      end
   endgenerate

   dec_act_e         act;
   logic [CNT_W-1:0] rld_val;
   logic             rld_gate;

   assign rld_gate = RELOAD_EN ? rld_enable : 1'b0;

   dec_action_sel #(.CNT_W(CNT_W)) u_sel (
      .tick_en   (tick_en),
      .cnt_wr_en (cnt_wr_en),
      .count     (count_o),
      .act       (act)
   );

   dec_reload_reg #(.CNT_W(CNT_W), .RELOAD_EN(RELOAD_EN)) u_rld (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rld_wr_en),
      .wr_data (rld_wr_data),
      .value   (rld_val)
   );

   dec_count_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .wr_data    (cnt_wr_data),
      .rld_enable (rld_gate),
      .rld_value  (rld_val),
      .count      (count_o),
      .expire     (expire_o)
   );

   assign reload_o = rld_val;
endmodule

// File: rtl/dec_reload_timer_chk.sv
module dec_reload_timer_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt_wr_data,
   input logic             rld_wr_en,
   input logic [CNT_W-1:0] rld_wr_data,
   input logic             rld_enable,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] reload_o,
   input logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr_en && count_o > ONE) |=> count_o == $past(count_o) - ONE);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr_en) |=> $stable(count_o));

   assert_event_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expire_o) |-> ($past(tick_en) && !$past(cnt_wr_en) && $past(count_o) == ONE));

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (!expire_o || $past(count_o) == ONE));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr_en && count_o == ONE && rld_enable && reload_o != '0)
      |=> count_o == $past(reload_o));

   assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr_en && count_o == ONE && !rld_enable) |=> count_o == '0);

   assert_zero_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr_en && count_o == ONE && reload_o == '0) |=> count_o == '0);

   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |=> (count_o == $past(cnt_wr_data) && !expire_o));

   assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0) |=> !expire_o);

   assert_reload_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rld_wr_en |=> reload_o == $past(rld_wr_data));
endmodule

bind dec_reload_timer dec_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .cnt_wr_en   (cnt_wr_en),
   .cnt_wr_data (cnt_wr_data),
   .rld_wr_en   (rld_wr_en),
   .rld_wr_data (rld_wr_data),
   .rld_enable  (rld_enable),
   .count_o     (count_o),
   .reload_o    (reload_o),
   .expire_o    (expire_o)
);

// File: tb/dec_reload_timer_test.sv
`timescale 1ns/1ps
module dec_reload_timer_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0, cnt_wr_en = 1'b0, rld_wr_en = 1'b0, rld_enable = 1'b0;
   logic [W-1:0] cnt_wr_data = '0, rld_wr_data = '0;
   logic [W-1:0] count_o, reload_o;
   logic         expire_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [W-1:0] m_cnt = '0, m_rld = '0;

   always #4 clk = ~clk;

   dec_reload_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr_en(cnt_wr_en),
      .cnt_wr_data(cnt_wr_data), .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data),
      .rld_enable(rld_enable), .count_o(count_o), .reload_o(reload_o),
      .expire_o(expire_o)
   );

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected next state from the requirements.
   function automatic void predict(input logic t, cw, input logic [W-1:0] cd,
                                   input logic re, input logic [W-1:0] cur,
                                   input logic [W-1:0] rl,
                                   output logic [W-1:0] nxt, output logic evt,
                                   output string tag);
      evt = 1'b0;
      nxt = cur;
      tag = "R2 hold";
      if (cw) begin
         nxt = cd;
         tag = (cd == '0) ? "R8 write zero" : "R7 write priority";
      end else if (t && cur == 1) begin
         evt = 1'b1;
         if (re && rl != '0) begin
            nxt = rl;
            tag = "R4 reload";
         end else begin
            nxt = '0;
            tag = re ? "R6 zero reload" : "R5 no reload";
         end
      end else if (t && cur != '0) begin
         nxt = cur - 1;
         tag = "R2 decrement";
      end else if (t) begin
         tag = "R5 parked at zero";
      end
   endfunction

   task automatic step(input logic t, cw, input logic [W-1:0] cd,
                       input logic rw, input logic [W-1:0] rd, input logic re);
      logic [W-1:0] n_cnt;
      logic         e_evt;
      string        tag;
      @(negedge clk);
      tick_en = t; cnt_wr_en = cw; cnt_wr_data = cd;
      rld_wr_en = rw; rld_wr_data = rd; rld_enable = re;
      predict(t, cw, cd, re, m_cnt, m_rld, n_cnt, e_evt, tag);
      @(posedge clk);
      #1;
      m_cnt = n_cnt;
      if (rw) m_rld = rd;
      check(count_o == m_cnt, tag, count_o, m_cnt);
      check(reload_o == m_rld, "R9 reload register", reload_o, m_rld);
      check(expire_o == e_evt, e_evt ? "R3 expiry pulse" : "R8 R3 no expiry",
            W'(expire_o), W'(e_evt));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      #20;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(count_o == '0, "R1 reset count", count_o, '0);
      check(reload_o == '0, "R1 reset reload", reload_o, '0);
      check(expire_o == 1'b0, "R1 reset expire", W'(expire_o), '0);

      // R8: ticking at zero and writing zero give nothing
      step(1, 0, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 1);
      // R2 countdown, then R5 expiry without reload, stay parked
      step(0, 1, 3, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      // R6: reload enabled with zero reload value
      step(0, 1, 1, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1);
      // R4 reload, back-to-back with reload of one
      step(0, 1, 2, 1, 1, 1);
      step(1, 0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1);
      // R9: reload write collides with expiry, old value used
      step(0, 0, 0, 1, 5, 1);
      step(1, 0, 0, 1, 9, 1);
      step(1, 0, 0, 0, 0, 1);
      // R7: write at count one while ticking, no expiry
      step(0, 1, 1, 0, 0, 1);
      step(1, 1, 7, 0, 0, 1);
      // R2 large count and wrap region
      step(0, 1, 32'hFFFF_FFFF, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1);

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic t, cw, rw, re;
         logic [W-1:0] cd, rd;
         t  = ($urandom % 4) != 0;
         cw = ($urandom % 12) == 0;
         rw = ($urandom % 10) == 0;
         re = ($urandom % 4) != 0;
         cd = ($urandom % 16 == 0) ? W'($urandom) : W'($urandom % 6);
         rd = ($urandom % 16 == 0) ? W'($urandom) : W'($urandom % 5);
         step(t, cw, cd, rw, rd, re);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule